// File: doc/BRIEF.md
# Parallel RGB Panel Scan Timer

This block produces the horizontal sync, vertical sync and data-enable waveforms for a parallel RGB display, advancing one raster position per pixel-clock enable. Software programs the line and frame lengths, the two sync pulse widths, a wait count per direction (sync pulse plus back porch) and the size of the visible window. It then turns on the sync outputs and sets the run bit. Each visible position also produces a one-cycle request strobe for a downstream pixel fetch unit.

A frame-base address is double-buffered. Software writes the next address at any time. The block copies it into the current address, which drives `frame_base_o`, when the scan enters position (0,0), and it pulses `frame_start_o` in the same cycle. To stop cleanly, software clears the keep-running bit. The block then completes the frame in progress and clears its own run bit, which software can poll.

Top module: `rgb_scan_timer`

## Requirements
- R1: After synchronous reset every register reads 0, run is clear, `frame_base_o` is 0, `pix_req_o` and `frame_start_o` are low, and `hsync_o`, `vsync_o` and `de_o` sit at 1, which is the inactive level for the default active-low selects.
- R2: The control word at byte address 0x00 holds these bits: 0 run, 1 keep-running, 2 sync-enable, 3 hsync active-high, 4 vsync active-high, 5 data-enable active-high, and 6 falling-edge select. A write to 0x00 replaces the word. A write to 0x04 sets the bits given as ones, and a write to 0x08 clears them. A read of 0x00 returns the word on `reg_rdata` one cycle after the address is presented.
- R3: A pixel tick is a cycle with run set and `pix_en` high. Each tick advances the column from 0 up to line length − 1 (address 0x10) and then wraps to 0. The wrap advances the line, and the line wraps at the frame length in lines (address 0x20). Without a tick the position holds.
- R4: The hsync pulse is active on columns below the hsync width (0x14). The vsync pulse is active on lines below the vsync width (0x24), which is counted in lines.
- R5: Data-enable is active on columns from the horizontal wait count (0x18) for the valid-pixel count (0x1C), on lines from the vertical wait count (0x28) for the active line count (0x2C). Each tick at such a position gives exactly one `pix_req_o` pulse.
- R6: Each of hsync, vsync and data-enable drives its active level as 1 when its active-high bit is set and as 0 when the bit is clear.
- R7: While sync-enable is clear, `hsync_o` and `vsync_o` stay at their inactive levels whatever the position.
- R8: A tick at position (0,0) pulses `frame_start_o` and copies the next base (0x30) into the current base, which is readable at 0x34 and drives `frame_base_o`. A next-base write in the same cycle is not copied until the following frame start.
- R9: When keep-running is clear and run is set, the block clears run by itself on the tick at the last position of the frame.
- R10: When run is cleared directly, the position returns to (0,0) and the three pins go to their inactive levels on the next cycle.
- R11: `pclk_fall_o` follows the falling-edge select bit.
- R12: All outputs are registered. A tick changes the pins one cycle later, and they hold between ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel-clock enable, one raster position per high cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address, used for both writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for reg_addr |
| hsync_o | output | 1 | Horizontal sync pin |
| vsync_o | output | 1 | Vertical sync pin |
| de_o | output | 1 | Data-enable pin |
| pix_req_o | output | 1 | One-cycle fetch request per visible pixel |
| frame_start_o | output | 1 | One-cycle pulse at each frame start |
| frame_base_o | output | 32 | Current frame base address |
| pclk_fall_o | output | 1 | Falling-edge sampling select for the pixel clock pad |

## Verification
Two functions can fall in the same cycle: the frame-start copy of the base address and a software write to the next-base register. Also, the self-clearing of run on the last tick of a frame can coincide with a control write. The bench follows its own model of the scan position and issues a next-base write on exactly the cycle whose tick lands on (0,0). It then checks that the frame started with the previously queued address and that the new one appears a frame later. A stop is also requested at a known line, and the bench checks that run stays set until the last position of that frame and reads back clear afterwards.

// File: rtl/rgbt_pkg.sv
package rgbt_pkg;
  localparam int CTRL_W = 7;
  localparam int B_RUN  = 0;
  localparam int B_KEEP = 1;
  localparam int B_SYNC = 2;
  localparam int B_HPOL = 3;
  localparam int B_VPOL = 4;
  localparam int B_DPOL = 5;
  localparam int B_FALL = 6;

  localparam logic [7:0] A_CTRL  = 8'h00;
  localparam logic [7:0] A_CSET  = 8'h04;
  localparam logic [7:0] A_CCLR  = 8'h08;
  localparam logic [7:0] A_HTOT  = 8'h10;
  localparam logic [7:0] A_HSW   = 8'h14;
  localparam logic [7:0] A_HWAIT = 8'h18;
  localparam logic [7:0] A_HVAL  = 8'h1C;
  localparam logic [7:0] A_VTOT  = 8'h20;
  localparam logic [7:0] A_VSW   = 8'h24;
  localparam logic [7:0] A_VWAIT = 8'h28;
  localparam logic [7:0] A_VLN   = 8'h2C;
  localparam logic [7:0] A_NEXT  = 8'h30;
  localparam logic [7:0] A_CUR   = 8'h34;
endpackage

// File: rtl/rgbt_regs.sv
module rgbt_regs
  import rgbt_pkg::*;
#(
  parameter int HTW = 18,
  parameter int HSW = 14,
  parameter int HWW = 12,
  parameter int VTW = 16,
  parameter int VSW = 18,
  parameter int AW  = 32,
  parameter int DW  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [7:0]        addr,
  input  logic [DW-1:0]     wdata,
  input  logic              stop_done,
  input  logic              fs_evt,
  output logic [CTRL_W-1:0] ctrl,
  output logic [HTW-1:0]    htot,
  output logic [HSW-1:0]    hsw,
  output logic [HWW-1:0]    hwait,
  output logic [HTW-1:0]    hval,
  output logic [VTW-1:0]    vtot,
  output logic [VSW-1:0]    vsw,
  output logic [VTW-1:0]    vwait,
  output logic [VTW-1:0]    vln,
  output logic [AW-1:0]     cur_base,
  output logic [DW-1:0]     rdata
);
  logic [CTRL_W-1:0] ctrl_base, ctrl_d;
  logic [AW-1:0]     nxt_q;
  logic [DW-1:0]     rd_mux;
  logic              ctrl_hit;

  assign ctrl_hit = wr && (addr == A_CTRL || addr == A_CSET || addr == A_CCLR);

  always_comb begin
    ctrl_base = ctrl;
    if (stop_done) ctrl_base[B_RUN] = 1'b0;
    ctrl_d = ctrl_base;
    if (wr) begin
      case (addr)
        A_CTRL:  ctrl_d = wdata[CTRL_W-1:0];
        A_CSET:  ctrl_d = ctrl_base | wdata[CTRL_W-1:0];
        A_CCLR:  ctrl_d = ctrl_base & ~wdata[CTRL_W-1:0];
        default: ctrl_d = ctrl_base;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0; htot <= '0; hsw <= '0; hwait <= '0; hval <= '0;
      vtot <= '0; vsw <= '0; vwait <= '0; vln <= '0;
      nxt_q <= '0; cur_base <= '0;
    end else begin
      ctrl <= ctrl_d;
      if (fs_evt) cur_base <= nxt_q;
      if (wr) begin
        case (addr)
          A_HTOT:  htot  <= wdata[HTW-1:0];
          A_HSW:   hsw   <= wdata[HSW-1:0];
          A_HWAIT: hwait <= wdata[HWW-1:0];
          A_HVAL:  hval  <= wdata[HTW-1:0];
          A_VTOT:  vtot  <= wdata[VTW-1:0];
          A_VSW:   vsw   <= wdata[VSW-1:0];
          A_VWAIT: vwait <= wdata[VTW-1:0];
          A_VLN:   vln   <= wdata[VTW-1:0];
          A_NEXT:  nxt_q <= wdata[AW-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_CTRL:  rd_mux = DW'(ctrl);
      A_HTOT:  rd_mux = DW'(htot);
      A_HSW:   rd_mux = DW'(hsw);
      A_HWAIT: rd_mux = DW'(hwait);
      A_HVAL:  rd_mux = DW'(hval);
      A_VTOT:  rd_mux = DW'(vtot);
      A_VSW:   rd_mux = DW'(vsw);
      A_VWAIT: rd_mux = DW'(vwait);
      A_VLN:   rd_mux = DW'(vln);
      A_NEXT:  rd_mux = DW'(nxt_q);
      A_CUR:   rd_mux = DW'(cur_base);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  // R8: frame start copies the base queued before that edge
  p_base_swap_r8: assert property (@(posedge clk) disable iff (rst)
    fs_evt |=> (cur_base == $past(nxt_q)));

  // R9: self-stop clears run unless software writes control in that cycle
  p_self_stop_r9: assert property (@(posedge clk) disable iff (rst)
    (stop_done && !ctrl_hit) |=> !ctrl[B_RUN]);
endmodule

// File: rtl/rgbt_scan.sv
module rgbt_scan #(
  parameter int HTW = 18,
  parameter int VTW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run,
  input  logic           pix_en,
  input  logic [HTW-1:0] htot,
  input  logic [VTW-1:0] vtot,
  output logic [HTW-1:0] h_pos,
  output logic [VTW-1:0] v_pos,
  output logic           tick,
  output logic           frame_last,
  output logic           fs_evt
);
  localparam int HXW = HTW + 1;
  localparam int VXW = VTW + 1;

  logic h_last, v_last;

  assign tick       = run && pix_en;
  assign h_last     = (HXW'(h_pos) + HXW'(1)) >= HXW'(htot);
  assign v_last     = (VXW'(v_pos) + VXW'(1)) >= VXW'(vtot);
  assign frame_last = h_last && v_last;
  assign fs_evt     = tick && (h_pos == '0) && (v_pos == '0);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      h_pos <= '0;
      v_pos <= '0;
    end else if (tick) begin
      if (h_last) begin
        h_pos <= '0;
        v_pos <= v_last ? '0 : v_pos + VTW'(1);
      end else begin
        h_pos <= h_pos + HTW'(1);
      end
    end
  end

  // R3: column wraps after the last position of a line
  p_col_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && h_last) |=> (h_pos == '0));

  // R3: no tick, no movement
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (run && !pix_en) |=> ($stable(h_pos) && $stable(v_pos)));

  // R10: a stopped scan sits at the origin
  p_idle_origin_r10: assert property (@(posedge clk) disable iff (rst)
    !run |=> (h_pos == '0 && v_pos == '0));
endmodule

// File: rtl/rgbt_pins.sv
module rgbt_pins #(
  parameter int HTW = 18,
  parameter int HSW = 14,
  parameter int HWW = 12,
  parameter int VTW = 16,
  parameter int VSW = 18
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run,
  input  logic           tick,
  input  logic           fs_evt,
  input  logic [HTW-1:0] h_pos,
  input  logic [VTW-1:0] v_pos,
  input  logic [HSW-1:0] hsw,
  input  logic [HWW-1:0] hwait,
  input  logic [HTW-1:0] hval,
  input  logic [VSW-1:0] vsw,
  input  logic [VTW-1:0] vwait,
  input  logic [VTW-1:0] vln,
  input  logic           sync_on,
  input  logic [2:0]     pol,
  output logic [2:0]     pin,
  output logic           req_o,
  output logic           fs_o
);
  localparam int HM  = (HTW > HSW) ? HTW : HSW;
  localparam int HCW = ((HM > HWW) ? HM : HWW) + 1;
  localparam int VCW = ((VTW > VSW) ? VTW : VSW) + 1;
  localparam int NSIG = 3;

  logic [NSIG-1:0] act_q, act_n, act_f, gate;
  logic [HCW-1:0]  h_x, h_end;
  logic [VCW-1:0]  v_x, v_end;
  logic            in_h, in_v;

  assign h_x   = HCW'(h_pos);
  assign v_x   = VCW'(v_pos);
  assign h_end = HCW'(hwait) + HCW'(hval);
  assign v_end = VCW'(vwait) + VCW'(vln);
  assign in_h  = (h_x >= HCW'(hwait)) && (h_x < h_end);
  assign in_v  = (v_x >= VCW'(vwait)) && (v_x < v_end);

  assign act_f[0] = h_x < HCW'(hsw);
  assign act_f[1] = v_x < VCW'(vsw);
  assign act_f[2] = in_h && in_v;
  assign gate     = {1'b1, sync_on, sync_on};

  always_comb begin
    if (!run)      act_n = '0;
    else if (tick) act_n = act_f;
    else           act_n = act_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
      req_o <= 1'b0;
      fs_o  <= 1'b0;
    end else begin
      act_q <= act_n;
      req_o <= tick && act_f[2];
      fs_o  <= fs_evt;
    end
  end

  for (genvar i = 0; i < NSIG; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) pin[i] <= 1'b1;
      else     pin[i] <= (act_n[i] && gate[i]) ? pol[i] : !pol[i];
    end
  end

  // R7: sync pins idle while sync output is off
  p_sync_off_r7: assert property (@(posedge clk) disable iff (rst)
    !sync_on |=> (pin[0] == !$past(pol[0]) && pin[1] == !$past(pol[1])));

  // R5: a fetch request only ever coincides with active data-enable
  p_req_in_de_r5: assert property (@(posedge clk) disable iff (rst)
    req_o |-> (pin[2] == $past(pol[2])));
endmodule

// File: rtl/rgb_scan_timer.sv
module rgb_scan_timer
  import rgbt_pkg::*;
#(
  parameter int HTW = 18,
  parameter int HSW = 14,
  parameter int HWW = 12,
  parameter int VTW = 16,
  parameter int VSW = 18,
  parameter int AW  = 32,
  parameter int DW  = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pix_en,
  input  logic          reg_wr,
  input  logic [7:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic          pix_req_o,
  output logic          frame_start_o,
  output logic [AW-1:0] frame_base_o,
  output logic          pclk_fall_o
);
  logic [CTRL_W-1:0] ctrl;
  logic [HTW-1:0]    htot, hval, h_pos;
  logic [HSW-1:0]    hsw;
  logic [HWW-1:0]    hwait;
  logic [VTW-1:0]    vtot, vwait, vln, v_pos;
  logic [VSW-1:0]    vsw;
  logic              tick, frame_last, fs_evt, stop_done;
  logic [2:0]        pin;

  assign stop_done = tick && frame_last && !ctrl[B_KEEP];

  rgbt_regs #(.HTW(HTW), .HSW(HSW), .HWW(HWW), .VTW(VTW), .VSW(VSW), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .stop_done(stop_done), .fs_evt(fs_evt), .ctrl(ctrl),
    .htot(htot), .hsw(hsw), .hwait(hwait), .hval(hval),
    .vtot(vtot), .vsw(vsw), .vwait(vwait), .vln(vln),
    .cur_base(frame_base_o), .rdata(reg_rdata)
  );

  rgbt_scan #(.HTW(HTW), .VTW(VTW)) u_scan (
    .clk(clk), .rst(rst), .run(ctrl[B_RUN]), .pix_en(pix_en),
    .htot(htot), .vtot(vtot), .h_pos(h_pos), .v_pos(v_pos),
    .tick(tick), .frame_last(frame_last), .fs_evt(fs_evt)
  );

  rgbt_pins #(.HTW(HTW), .HSW(HSW), .HWW(HWW), .VTW(VTW), .VSW(VSW)) u_pins (
    .clk(clk), .rst(rst), .run(ctrl[B_RUN]), .tick(tick), .fs_evt(fs_evt),
    .h_pos(h_pos), .v_pos(v_pos), .hsw(hsw), .hwait(hwait), .hval(hval),
    .vsw(vsw), .vwait(vwait), .vln(vln), .sync_on(ctrl[B_SYNC]),
    .pol({ctrl[B_DPOL], ctrl[B_VPOL], ctrl[B_HPOL]}),
    .pin(pin), .req_o(pix_req_o), .fs_o(frame_start_o)
  );

  assign hsync_o     = pin[0];
  assign vsync_o     = pin[1];
  assign de_o        = pin[2];
  assign pclk_fall_o = ctrl[B_FALL];
endmodule

// File: tb/tb_rgb_scan_timer.sv
`timescale 1ns/1ps
module tb_rgb_scan_timer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pix_en = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata, frame_base_o;
  logic hsync_o, vsync_o, de_o, pix_req_o, frame_start_o, pclk_fall_o;

  always #2 clk = ~clk;

  rgb_scan_timer dut (
    .clk(clk), .rst(rst), .pix_en(pix_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .de_o(de_o), .pix_req_o(pix_req_o), .frame_start_o(frame_start_o),
    .frame_base_o(frame_base_o), .pclk_fall_o(pclk_fall_o)
  );

  int checks = 0, fails = 0, en_div = 1;
  bit mval = 0, done = 0;
  string scene = "R1 reset";

  // behavioural reference state
  logic [31:0] m_ctrl, m_next, m_cur, cb;
  int m_ht, m_hsw, m_hw, m_hv, m_vt, m_vsw, m_vw, m_vl, m_h, m_v;
  bit a_hs, a_vs, a_de, tk, hl, vl, fh, fv, fd, sd, run;
  logic e_hs, e_vs, e_de, e_req, e_fs, e_fall;
  logic [31:0] e_base, e_rd;

  function automatic logic [31:0] rd_model(input logic [7:0] a);
    case (a)
      8'h00: return m_ctrl;
      8'h10: return m_ht;  8'h14: return m_hsw; 8'h18: return m_hw; 8'h1C: return m_hv;
      8'h20: return m_vt;  8'h24: return m_vsw; 8'h28: return m_vw; 8'h2C: return m_vl;
      8'h30: return m_next; 8'h34: return m_cur;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = 0; m_next = 0; m_cur = 0;
      m_ht = 0; m_hsw = 0; m_hw = 0; m_hv = 0; m_vt = 0; m_vsw = 0; m_vw = 0; m_vl = 0;
      m_h = 0; m_v = 0; a_hs = 0; a_vs = 0; a_de = 0;
      e_hs = 1; e_vs = 1; e_de = 1; e_req = 0; e_fs = 0; e_base = 0; e_rd = 0; e_fall = 0;
      mval = 1;
    end else begin
      run = m_ctrl[0];
      tk = run && pix_en;
      hl = (m_h + 1 >= m_ht);
      vl = (m_v + 1 >= m_vt);
      fh = m_h < m_hsw;
      fv = m_v < m_vsw;
      fd = (m_h >= m_hw) && (m_h < m_hw + m_hv) && (m_v >= m_vw) && (m_v < m_vw + m_vl);
      if (!run) begin a_hs = 0; a_vs = 0; a_de = 0; end
      else if (tk) begin a_hs = fh; a_vs = fv; a_de = fd; end
      e_hs = (a_hs && m_ctrl[2]) ? m_ctrl[3] : !m_ctrl[3];
      e_vs = (a_vs && m_ctrl[2]) ? m_ctrl[4] : !m_ctrl[4];
      e_de = a_de ? m_ctrl[5] : !m_ctrl[5];
      e_req = tk && fd;
      e_fs = tk && m_h == 0 && m_v == 0;
      e_rd = rd_model(reg_addr);
      sd = tk && hl && vl && !m_ctrl[1];
      if (!run) begin m_h = 0; m_v = 0; end
      else if (tk) begin
        if (hl) begin m_h = 0; m_v = vl ? 0 : m_v + 1; end
        else m_h = m_h + 1;
      end
      if (e_fs) m_cur = m_next;
      cb = m_ctrl;
      if (sd) cb[0] = 1'b0;
      m_ctrl = cb;
      if (reg_wr) begin
        case (reg_addr)
          8'h00: m_ctrl = reg_wdata & 32'h7F;
          8'h04: m_ctrl = cb | (reg_wdata & 32'h7F);
          8'h08: m_ctrl = cb & ~reg_wdata & 32'h7F;
          8'h10: m_ht  = reg_wdata & 32'h3FFFF;
          8'h14: m_hsw = reg_wdata & 32'h3FFF;
          8'h18: m_hw  = reg_wdata & 32'hFFF;
          8'h1C: m_hv  = reg_wdata & 32'h3FFFF;
          8'h20: m_vt  = reg_wdata & 32'hFFFF;
          8'h24: m_vsw = reg_wdata & 32'h3FFFF;
          8'h28: m_vw  = reg_wdata & 32'hFFFF;
          8'h2C: m_vl  = reg_wdata & 32'hFFFF;
          8'h30: m_next = reg_wdata;
          default: ;
        endcase
      end
      e_base = m_cur;
      e_fall = m_ctrl[6];
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL [%s] %s actual=%h expected=%h t=%0t", scene, what, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (mval && !done) begin
      chk("hsync R4/R6", hsync_o, e_hs);
      chk("vsync R4/R6", vsync_o, e_vs);
      chk("de R5/R6", de_o, e_de);
      chk("pix_req R5", pix_req_o, e_req);
      chk("frame_start R8", frame_start_o, e_fs);
      chk("frame_base R8", frame_base_o, e_base);
      chk("rdata R2", reg_rdata, e_rd);
      chk("pclk_fall R11", pclk_fall_o, e_fall);
    end
  end

  initial begin
    int pc = 0;
    forever begin
      @(negedge clk);
      pc++;
      pix_en = (en_div <= 1) ? 1'b1 : ((pc % en_div) == 0);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 8'h00;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    scene = "R1 reset";
    chk("R1 hsync idle", hsync_o, 1'b1);
    chk("R1 vsync idle", vsync_o, 1'b1);
    chk("R1 de idle", de_o, 1'b1);
    chk("R1 base zero", frame_base_o, 0);
    chk("R1 req low", pix_req_o, 1'b0);

    // columns 0..9, hsync 0..1, data 3..7; lines 0..5, vsync 0, data lines 2..4
    wr(8'h10, 10); wr(8'h14, 2); wr(8'h18, 3); wr(8'h1C, 5);
    wr(8'h20, 6);  wr(8'h24, 1); wr(8'h28, 2); wr(8'h2C, 3);
    wr(8'h30, 32'h1000);

    scene = "R2 control aliases";
    wr(8'h00, 32'h06);
    wr(8'h04, 32'h01);
    @(negedge clk);
    chk("R2 readback after set alias", reg_rdata, 32'h07);

    scene = "R3 R4 R5 continuous ticks";
    idle(130);

    scene = "R12 R3 sparse ticks";
    en_div = 3;
    idle(200);
    en_div = 1;

    scene = "R6 polarity high";
    wr(8'h04, 32'h38);
    idle(70);

    scene = "R7 sync disabled";
    wr(8'h08, 32'h04);
    idle(70);
    wr(8'h04, 32'h04);

    scene = "R8 next-base write on frame start";
    do @(negedge clk); while (!(m_h == 5 && m_v == 3));
    reg_wr = 1'b1; reg_addr = 8'h30; reg_wdata = 32'h1800;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 8'h00;
    while (!(m_h == 0 && m_v == 0)) @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h30; reg_wdata = 32'h2000;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 8'h00;
    chk("R8 collision keeps queued base", frame_base_o, 32'h1800);
    idle(61);
    chk("R8 new base one frame later", frame_base_o, 32'h2000);

    scene = "R9 stop at frame end";
    while (!(m_h == 0 && m_v == 1)) @(negedge clk);
    wr(8'h08, 32'h02);
    idle(4);
    chk("R9 still running mid-frame", reg_rdata[0], 1'b1);
    idle(60);
    chk("R9 run cleared by block", reg_rdata[0], 1'b0);
    chk("R9 de idle after stop", de_o, 1'b0);

    scene = "R10 direct run clear";
    wr(8'h04, 32'h03);
    idle(27);
    wr(8'h08, 32'h01);
    @(negedge clk);
    chk("R10 de inactive", de_o, 1'b0);
    chk("R10 hsync inactive", hsync_o, 1'b0);
    chk("R10 no request", pix_req_o, 1'b0);

    scene = "R11 falling edge select";
    wr(8'h04, 32'h40);
    chk("R11 pclk_fall set", pclk_fall_o, 1'b1);
    wr(8'h08, 32'h40);
    chk("R11 pclk_fall clear", pclk_fall_o, 1'b0);

    scene = "R12 restart sparse";
    en_div = 2;
    wr(8'h04, 32'h01);
    idle(150);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog R1-chain hung actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule